// File: doc/BRIEF.md
# Dual-Channel Modulo-255 Pulse-Width Modulator

This block drives two pulse-width modulated outputs from a single shared time base. A system-clock tick enable feeds an 8-bit prescaler whose reload value P is set by a register write. The prescaler emits one step every (1+P) ticks. Each step advances a shared 8-bit period counter that runs from 0 up to 254 and then returns to 0. A full output period is therefore 255 steps, and the repetition rate is fCLK/((1+P)·255).

Each channel holds its own 8-bit duty register. The channel output is low while the duty value is greater than the counter, and high otherwise. Because the counter never reaches 255, a duty of 00h holds the output high and a duty of FFh holds it low. A duty write acts on the comparison in the same cycle it is presented, so it does not wait for a period boundary. Each output comes from a flop, which keeps it free of glitches. The prescaler reload register can be read back, and the readback gives the programmed reload value, not the running prescaler count.

All pins are plain control and status signals: write strobes carry no handshake and are accepted in every cycle, so no back-pressure exists.

Top module: `dual_pwm_mod255`

## Requirements
- R1: After reset the prescaler count, the period counter, the reload register and both duty registers are zero, both outputs are high, and the reload readback is 0.
- R2: The shared period counter advances by one on each prescaler step, going 0,1,…,254 and then back to 0, so it never holds 255.
- R3: With reload value P the prescaler gives one step for every (1+P) cycles in which tick_i is high. In cycles with tick_i low, neither the prescaler nor the counter moves.
- R4: At each clock edge, pwm_o[c] takes the value 0 if the effective duty of channel c is greater than the counter value before that edge, and 1 otherwise. This gives one register of latency.
- R5: A duty value of 00h gives a constant high output on that channel.
- R6: A duty value of FFh gives a constant low output on that channel.
- R7: When duty_wr_i[c] is high, the value on duty_data_i is the effective duty for that same edge. The output updated at that edge already uses the new value, with no wait for the period end.
- R8: One cycle after a write of scale_data_i with scale_wr_i high, scale_rd_o equals the written value. It keeps that value until the next write, whatever the running prescaler count is.
- R9: Both channels compare against the same counter. Channel c uses duty_data_i bits [8c+7:8c].

Each `rN` tag in the assertion labels and bench messages refers to the requirement with that number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable for the prescaler |
| scale_wr_i | input | 1 | Write strobe for the prescaler reload register |
| scale_data_i | input | 8 | New prescaler reload value |
| duty_wr_i | input | 2 | Per-channel duty write strobes |
| duty_data_i | input | 16 | Duty values, channel c in bits [8c+7:8c] |
| scale_rd_o | output | 8 | Readback of the reload register |
| pwm_o | output | 2 | Registered PWM outputs |

## Verification
The assertions check on every cycle that the counter stays in range and wraps after 254, that it holds when no step occurs, and that the prescaler holds without a tick. They also check that the outputs stay pinned under duty 00h and FFh, that a zero-duty write shows up at once, and that the readback follows writes. Some behaviour is visible only in the bench's scenarios. This includes the full duty-versus-counter relation over every duty value and counter phase, the exact step spacing for several reload values under both dense and sparse ticks, and the way mid-period duty writes interleave with the shared counter.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Last counter value before wrap: modulo (2^w - 1).
  function automatic int unsigned wrap_last(input int unsigned w);
    return (1 << w) - 2;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             rl_wr_i,
  input  logic [PRE_W-1:0] rl_data_i,
  output logic [PRE_W-1:0] rl_q_o,
  output logic             step_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] rl_q;
  logic             hit;

  assign hit    = (pre_q >= rl_q);
  assign step_o = tick_i && hit;
  assign rl_q_o = rl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q <= '0;
    end else if (rl_wr_i) begin
      rl_q <= rl_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (tick_i) begin
      pre_q <= hit ? '0 : pre_q + 1'b1;
    end
  end

  // R3: no tick, no prescaler motion
  p_pre_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pre_q));
  // R3: count restarts after a step
  p_pre_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (pre_q == '0));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(pwm_pkg::wrap_last(CNT_W));

  logic [CNT_W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: counter never leaves 0..LAST
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R2: wrap after the last value
  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && cnt_q == LAST) |=> (cnt_q == '0));
  // R3: counter holds between steps
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] duty_eff;
  logic             pwm_q;

  // New duty bypasses the register so it acts in the write cycle.
  assign duty_eff = wr_i ? data_i : duty_q;
  assign pwm_o    = pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      pwm_q  <= 1'b1;
    end else begin
      if (wr_i) duty_q <= data_i;
      pwm_q <= !(duty_eff > cnt_i);
    end
  end

  // R5: zero duty keeps the output high
  p_zero_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && duty_q == '0) |=> pwm_q);
  // R6: full duty keeps the output low
  p_full_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && duty_q == ALL_ONES) |=> !pwm_q);
  // R7: a fresh write acts at the very next edge
  p_imm_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && data_i == ALL_ONES) |=> !pwm_q);
  p_imm_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && data_i == '0) |=> pwm_q);
endmodule

// File: rtl/dual_pwm_mod255.sv
module dual_pwm_mod255 #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned NUM_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic                    scale_wr_i,
  input  logic [PRE_W-1:0]        scale_data_i,
  input  logic [NUM_CH-1:0]       duty_wr_i,
  input  logic [NUM_CH*CNT_W-1:0] duty_data_i,
  output logic [PRE_W-1:0]        scale_rd_o,
  output logic [NUM_CH-1:0]       pwm_o
);
  logic             step;
  logic [CNT_W-1:0] cnt;

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .rl_wr_i  (scale_wr_i),
    .rl_data_i(scale_data_i),
    .rl_q_o   (scale_rd_o),
    .step_o   (step)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(step),
    .cnt_o (cnt)
  );

  // R9: every channel sees the one shared counter
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (duty_wr_i[c]),
      .data_i(duty_data_i[c*CNT_W +: CNT_W]),
      .cnt_i (cnt),
      .pwm_o (pwm_o[c])
    );
  end

  // R8: readback shows the written reload value
  p_scale_rb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scale_wr_i |=> (scale_rd_o == $past(scale_data_i)));
  p_scale_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !scale_wr_i |=> $stable(scale_rd_o));
endmodule

// File: tb/tb_dual_pwm_mod255.sv
module tb_dual_pwm_mod255;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        scale_wr_i = 1'b0;
  logic [7:0]  scale_data_i = '0;
  logic [1:0]  duty_wr_i = '0;
  logic [15:0] duty_data_i = '0;
  logic [7:0]  scale_rd_o;
  logic [1:0]  pwm_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of requirement state
  int m_pre = 0, m_cnt = 0, m_rl = 0;
  int m_duty [2] = '{0, 0};
  logic [1:0] e_pwm = 2'b11;
  int e_rb = 0;
  string e_tag [2] = '{"R1", "R1"};

  dual_pwm_mod255 dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .scale_wr_i(scale_wr_i), .scale_data_i(scale_data_i),
    .duty_wr_i(duty_wr_i), .duty_data_i(duty_data_i),
    .scale_rd_o(scale_rd_o), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: compare results of the previous edge, then drive and predict.
  task automatic cyc(input logic tk, input logic [1:0] wr, input int d0, input int d1,
                     input logic wp, input int p);
    int eff;
    logic stp;
    @(negedge clk);
    for (int c = 0; c < 2; c++) check(e_tag[c], int'(pwm_o[c]), int'(e_pwm[c]));
    check("R8", int'(scale_rd_o), e_rb);
    tick_i = tk; duty_wr_i = wr; duty_data_i = {8'(d1), 8'(d0)};
    scale_wr_i = wp; scale_data_i = 8'(p);
    for (int c = 0; c < 2; c++) begin
      eff = wr[c] ? (c == 0 ? d0 : d1) : m_duty[c];
      e_pwm[c] = !(eff > m_cnt);                               // R4
      e_tag[c] = (eff == 0) ? "R5" : (eff == 255) ? "R6" : wr[c] ? "R7" : "R4";
      m_duty[c] = eff;
    end
    stp = tk && (m_pre >= m_rl);                               // R3
    if (tk) m_pre = stp ? 0 : m_pre + 1;
    if (stp) m_cnt = (m_cnt == 254) ? 0 : m_cnt + 1;           // R2
    if (wp) m_rl = p;
    e_rb = m_rl;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", int'(pwm_o), 3);
    check("R1", int'(scale_rd_o), 0);
    rst_n = 1'b1;
    // R1: with no tick the counter rests at 0, duty 0 -> high
    for (int i = 0; i < 5; i++) cyc(1'b0, 2'b00, 0, 0, 1'b0, 0);

    // R4/R5/R6/R9: exhaustive duty sweep, P=0, complementary channels
    for (int d = 0; d < 256; d++) begin
      cyc(1'b1, 2'b11, d, 255 - d, 1'b0, 0);
      for (int i = 0; i < 255; i++) cyc(1'b1, 2'b00, 0, 0, 1'b0, 0);
    end

    // R3/R8: slower prescale, dense ticks
    cyc(1'b1, 2'b11, 8'h80, 8'h01, 1'b1, 3);
    for (int i = 0; i < 2100; i++) cyc(1'b1, 2'b00, 0, 0, 1'b0, 0);

    // R3/R7/R8: sparse ticks, mid-period writes of duty and reload
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] w;
      w = (i % 97 == 0) ? 2'b01 : (i % 131 == 0) ? 2'b10 : 2'b00;
      cyc((i % 3) == 0, w, (i * 7) % 256, (i * 13) % 256,
          (i % 1000) == 500, (i / 1000) + 1);
    end

    // R7: write FFh then 00h back-to-back
    cyc(1'b1, 2'b11, 255, 0, 1'b0, 0);
    cyc(1'b1, 2'b11, 0, 255, 1'b0, 0);
    cyc(1'b0, 2'b00, 0, 0, 1'b0, 0);
    cyc(1'b0, 2'b00, 0, 0, 1'b0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule